// File: doc/BRIEF.md
# Block-Device Read Controller with Geometry Translation and DMA

This block sits between a CPU register port and main memory and serves sector reads from a storage medium. Software programs a logical block number and a destination byte address, then writes a start command. The controller maps the linear block number onto a physical position given as surface, track and sector. It then streams the whole sector into memory, one 32-bit word per accepted beat, with no software involvement for each word. When the copy is finished it raises an interrupt, which stays high until software acknowledges it.

The medium is modelled as deterministic content. Each word of a sector encodes its physical position and its word index, so the translation can be seen in the data that reaches memory. A block number at or beyond the device capacity finishes at once with an error flag and writes nothing. A start command that arrives during a transfer is dropped and recorded in a sticky overrun flag.

Top module: `blkdev_dma_ctrl`

## Requirements
- R1: After reset, irq_o is low, mem_req_o is low and the status word (register offset 0) reads 0.
- R2: With S sectors per track and T tracks per surface (defaults 8 and 16), block n maps to sector = n mod S, track = (n / S) mod T and surface = n / (S*T). Each memory word i carries (surface<<24)|(track<<16)|(sector<<8)|i.
- R3: A valid read writes SECTOR_BYTES/4 words (128 by default). Word i goes to destination + 4*i, in ascending order.
- R4: While mem_req_o is high and mem_ready_i is low, mem_addr_o and mem_wdata_o hold their values and the request stays up.
- R5: Status bit 0 (busy) is 1 from the cycle after an accepted start until completion. irq_o rises in the same cycle that busy falls.
- R6: irq_o stays high until any write to offset 3 (acknowledge). That write clears it.
- R7: A block number of S*T*surfaces or more sets status bit 1 (error), makes no memory writes and still raises irq_o. The next accepted start clears the error bit.
- R8: A start written while busy is ignored: the running transfer completes unchanged. The write sets status bit 2 (overrun), which stays set until an acknowledge write with data bit 1 set.
- R9: Register map: offset 0 write is the command, and only data bit 0 = 1 starts a read. Offset 0 read is the status. Offset 1 holds the block number and offset 2 the destination address; both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the current word |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The hardest case to reach from the ports is a second start that arrives during a live transfer. It must leave the running copy untouched while the overrun flag records it. The bench issues that start right after a legal one and also rewrites the block-number register at the same time, so any leak would show as wrong data words. Long stalls come from holding mem_ready_i low for a fixed stretch at the first beat; elsewhere ready is random. Geometry boundaries are covered by directed block numbers at sector, track and surface wrap points, at the last valid block and at the first invalid one.

// File: rtl/blkdev_pkg.sv
package blkdev_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} dma_state_e;

  localparam logic [1:0] OFS_CMD  = 2'd0;
  localparam logic [1:0] OFS_LBN  = 2'd1;
  localparam logic [1:0] OFS_DEST = 2'd2;
  localparam logic [1:0] OFS_ACK  = 2'd3;
endpackage

// File: rtl/blkdev_geom.sv
module blkdev_geom #(
  parameter int SPT   = 8,
  parameter int TPS   = 16,
  parameter int SURF  = 4,
  parameter int SEC_W = 3,
  parameter int TRK_W = 4,
  parameter int SRF_W = 2
) (
  input  logic [31:0]      lbn_i,
  output logic [SEC_W-1:0] sector_o,
  output logic [TRK_W-1:0] track_o,
  output logic [SRF_W-1:0] surface_o,
  output logic             valid_o
);
  localparam logic [31:0] CAP = 32'(SPT * TPS * SURF);

  logic [31:0] lin_trk;

  always_comb begin
    lin_trk   = lbn_i / 32'(SPT);
    sector_o  = SEC_W'(lbn_i % 32'(SPT));
    track_o   = TRK_W'(lin_trk % 32'(TPS));
    surface_o = SRF_W'(lin_trk / 32'(TPS));
    valid_o   = lbn_i < CAP;
  end
endmodule

// File: rtl/blkdev_dma.sv
module blkdev_dma
  import blkdev_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int SEC_W = 3,
  parameter int TRK_W = 4,
  parameter int SRF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             lbn_ok_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic [TRK_W-1:0] track_i,
  input  logic [SRF_W-1:0] surface_i,
  input  logic [31:0]      dest_i,
  input  logic             mem_ready_i,
  output logic             mem_req_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  dma_state_e       state_q;
  logic [SEC_W-1:0] sec_q;
  logic [TRK_W-1:0] trk_q;
  logic [SRF_W-1:0] srf_q;
  logic [31:0]      addr_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_q;
  logic             beat;

  assign beat = (state_q == ST_XFER) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sec_q   <= '0;
      trk_q   <= '0;
      srf_q   <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sec_q   <= sector_i;
          trk_q   <= track_i;
          srf_q   <= surface_i;
          addr_q  <= dest_i;
          idx_q   <= '0;
          err_q   <= !lbn_ok_i;
          state_q <= lbn_ok_i ? ST_XFER : ST_DONE;
        end
        ST_XFER: if (beat) begin
          addr_q <= addr_q + 32'd4;
          idx_q  <= idx_q + 1'b1;
          if (idx_q == LAST) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // medium model: each word encodes its physical position
  assign mem_wdata_o = (32'(srf_q) << 24) | (32'(trk_q) << 16) | (32'(sec_q) << 8) | 32'(idx_q);
  assign mem_addr_o  = addr_q;
  assign mem_req_o   = state_q == ST_XFER;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign err_o       = err_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (mem_req_o && mem_ready_i && idx_q != LAST) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 32'd4)); // R3
  AST_BAD_LBN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_o && start_i && !lbn_ok_i) |=> (!mem_req_o && done_o)); // R7
endmodule

// File: rtl/blkdev_regs.sv
module blkdev_regs
  import blkdev_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic        done_i,
  input  logic        err_i,
  output logic [31:0] rdata_o,
  output logic        start_o,
  output logic [31:0] lbn_o,
  output logic [31:0] dest_o,
  output logic        irq_o
);
  logic [31:0] lbn_q, dest_q;
  logic        irq_q, err_q, ovr_q;
  logic        cmd_wr, ack_wr;

  assign cmd_wr  = we_i && (addr_i == OFS_CMD) && wdata_i[0];
  assign ack_wr  = we_i && (addr_i == OFS_ACK);
  assign start_o = cmd_wr && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbn_q  <= '0;
      dest_q <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == OFS_LBN)  lbn_q  <= wdata_i;
      if (we_i && addr_i == OFS_DEST) dest_q <= wdata_i;
      if (start_o) err_q <= 1'b0;
      else if (done_i) err_q <= err_i;
      if (done_i) irq_q <= 1'b1;
      else if (ack_wr) irq_q <= 1'b0;
      if (cmd_wr && busy_i) ovr_q <= 1'b1;
      else if (ack_wr && wdata_i[1]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CMD:  rdata_o = {29'd0, ovr_q, err_q, busy_i};
      OFS_LBN:  rdata_o = lbn_q;
      OFS_DEST: rdata_o = dest_q;
      default:  rdata_o = '0;
    endcase
  end

  assign lbn_o  = lbn_q;
  assign dest_o = dest_q;
  assign irq_o  = irq_q;

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (irq_q && !ack_wr) |=> irq_q); // R6
  AST_IRQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni) (ack_wr && !done_i) |=> !irq_q); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_wr && busy_i) |=> ovr_q); // R8
  AST_IRQ_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_i |=> (irq_q && !busy_i)); // R5
endmodule

// File: rtl/blkdev_dma_ctrl.sv
module blkdev_dma_ctrl #(
  parameter int SECTOR_BYTES      = 512,
  parameter int SECTORS_PER_TRACK = 8,
  parameter int TRACKS            = 16,
  parameter int SURFACES          = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ready_i,
  output logic        irq_o
);
  localparam int WORDS = SECTOR_BYTES / 4;
  localparam int SEC_W = (SECTORS_PER_TRACK > 1) ? $clog2(SECTORS_PER_TRACK) : 1;
  localparam int TRK_W = (TRACKS > 1) ? $clog2(TRACKS) : 1;
  localparam int SRF_W = (SURFACES > 1) ? $clog2(SURFACES) : 1;

  logic             start, busy, done, err, lbn_ok;
  logic [31:0]      lbn, dest;
  logic [SEC_W-1:0] sector;
  logic [TRK_W-1:0] track;
  logic [SRF_W-1:0] surface;

  blkdev_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .done_i(done), .err_i(err),
    .rdata_o(reg_rdata_o), .start_o(start), .lbn_o(lbn), .dest_o(dest), .irq_o
  );

  blkdev_geom #(
    .SPT(SECTORS_PER_TRACK), .TPS(TRACKS), .SURF(SURFACES),
    .SEC_W(SEC_W), .TRK_W(TRK_W), .SRF_W(SRF_W)
  ) u_geom (
    .lbn_i(lbn), .sector_o(sector), .track_o(track), .surface_o(surface), .valid_o(lbn_ok)
  );

  blkdev_dma #(
    .WORDS(WORDS), .SEC_W(SEC_W), .TRK_W(TRK_W), .SRF_W(SRF_W)
  ) u_dma (
    .clk_i, .rst_ni,
    .start_i(start), .lbn_ok_i(lbn_ok),
    .sector_i(sector), .track_i(track), .surface_i(surface), .dest_i(dest),
    .mem_ready_i, .mem_req_o, .mem_addr_o, .mem_wdata_o,
    .busy_o(busy), .done_o(done), .err_o(err)
  );
endmodule

// File: tb/blkdev_dma_ctrl_bench.sv
module blkdev_dma_ctrl_bench;
  localparam int SPT = 8, TPS = 16, SRF = 4, WORDS = 128;
  localparam int CAP = SPT * TPS * SRF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_ready = 1'b1, irq;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0, fails = 0, cycles = 0;
  int cap_cnt = 0, stall_bad = 0;
  logic [31:0] cap_addr [256];
  logic [31:0] cap_data [256];
  logic        hold_low = 1'b0, stall_pend = 1'b0;
  logic [31:0] stall_addr, stall_data;

  always #5 clk = ~clk;

  blkdev_dma_ctrl u_blkdev_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .irq_o(irq)
  );

  always @(negedge clk) mem_ready <= hold_low ? 1'b0 : (($urandom % 4) != 0);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (stall_pend && (!mem_req || mem_addr != stall_addr || mem_wdata != stall_data))
      stall_bad <= stall_bad + 1;
    stall_pend <= mem_req && !mem_ready;
    stall_addr <= mem_addr;
    stall_data <= mem_wdata;
    if (mem_req && mem_ready && cap_cnt < 256) begin
      cap_addr[cap_cnt] <= mem_addr;
      cap_data[cap_cnt] <= mem_wdata;
      cap_cnt <= cap_cnt + 1;
    end
  end

  function automatic logic [31:0] exp_word(input int lbn, input int i);
    int sec = lbn % SPT;
    int trk = (lbn / SPT) % TPS;
    int srf = lbn / (SPT * TPS);
    return (32'(srf) << 24) | (32'(trk) << 16) | (32'(sec) << 8) | 32'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic do_xfer(input int lbn, input logic [31:0] dest, input bit ovr, input bit stall);
    logic [31:0] st;
    bit bad = (lbn >= CAP);
    bit prev_busy, seen;
    int first_bad;
    wr(2'd1, 32'(lbn));
    wr(2'd2, dest);
    rd(2'd1, st); check("R9 lbn readback", st, 32'(lbn));
    rd(2'd2, st); check("R9 dest readback", st, dest);
    cap_cnt = 0; stall_bad = 0;
    hold_low = stall;
    wr(2'd0, 32'd1);
    rd(2'd0, st); check("R5 busy after start", 32'(st[0]), 32'd1);
    if (ovr) begin
      wr(2'd1, 32'(lbn ^ 5));
      wr(2'd0, 32'd1);
      rd(2'd0, st); check("R8 overrun set", 32'(st[2]), 32'd1);
    end
    if (stall) begin
      repeat (25) @(negedge clk);
      check("R4 no beat while not ready", 32'(cap_cnt), 32'd0);
      check("R4 request held", 32'(mem_req), 32'd1);
      hold_low = 1'b0;
    end
    prev_busy = 1'b1; seen = 1'b0;
    for (int t = 0; t < 3000 && !seen; t++) begin
      rd(2'd0, st);
      if (irq) begin
        seen = 1'b1;
        check("R5 busy low with irq", 32'(st[0]), 32'd0);
        check("R5 busy high cycle before irq", 32'(prev_busy), 32'd1);
        check("R7 error bit", 32'(st[1]), 32'(bad));
      end else begin
        prev_busy = st[0];
        @(negedge clk);
      end
    end
    check("R5 irq raised", 32'(seen), 32'd1);
    check("R3 word count", 32'(cap_cnt), bad ? 32'd0 : 32'(WORDS));
    check("R4 stall hold", 32'(stall_bad), 32'd0);
    first_bad = -1;
    for (int i = 0; i < cap_cnt && i < WORDS; i++)
      if (first_bad < 0 && (cap_addr[i] != dest + 32'(4 * i) || cap_data[i] != exp_word(lbn, i)))
        first_bad = i;
    if (first_bad >= 0) begin
      check("R3 address", cap_addr[first_bad], dest + 32'(4 * first_bad));
      check("R2 data", cap_data[first_bad], exp_word(lbn, first_bad));
    end else checks++;
    repeat (3) @(negedge clk);
    check("R6 irq held", 32'(irq), 32'd1);
    wr(2'd3, ovr ? 32'd2 : 32'd0);
    check("R6 irq cleared by ack", 32'(irq), 32'd0);
    rd(2'd0, st); check("R8 overrun state after ack", 32'(st[2]), 32'd0);
  endtask

  initial begin
    logic [31:0] st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 irq reset", 32'(irq), 32'd0);
    check("R1 req reset", 32'(mem_req), 32'd0);
    rd(2'd0, st); check("R1 status reset", st, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd0, 32'd2);  // bit0 clear: not a start
    rd(2'd0, st); check("R9 non-start command ignored", 32'(st[0]), 32'd0);
    check("R9 no request", 32'(mem_req), 32'd0);
    do_xfer(0, 32'h0000_1000, 1'b0, 1'b1);
    do_xfer(7, 32'h0000_2000, 1'b0, 1'b0);
    do_xfer(8, 32'h0000_3000, 1'b0, 1'b0);
    do_xfer(127, 32'h0000_4000, 1'b0, 1'b0);
    do_xfer(128, 32'h0001_0000, 1'b0, 1'b0);
    do_xfer(CAP - 1, 32'h0002_0000, 1'b0, 1'b0);
    do_xfer(CAP, 32'h0003_0000, 1'b0, 1'b0);       // R7 first invalid block
    do_xfer(5, 32'h0004_0000, 1'b0, 1'b0);         // R7 error cleared by next start
    do_xfer(300, 32'h0005_0000, 1'b1, 1'b0);       // R8 start while busy
    do_xfer(CAP + 77, 32'h0006_0000, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++)
      do_xfer(int'($urandom % CAP), {$urandom % 32'h0010_0000, 2'b00}, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule